// File: doc/BRIEF.md
# Write-Once Snooping Private Cache

This block is a small direct-mapped, write-deferred cache placed between one processor port and a shared bus that other masters also use and that every cache watches. Coherence comes from a four-state write-once protocol. A line is Invalid, Valid (clean, possibly shared), Reserved (clean, held alone after one write-through) or Dirty (held alone, memory stale). The first processor write to a clean line is sent to the bus so that every other copy is dropped. After that, writes stay in the cache.

The processor side raises `cpu_req` and holds it, with its address and data, until `cpu_ready` pulses. Hits complete in the request cycle. Misses first write back a Dirty victim if there is one, and then fetch the line with a bus read. The block masters the bus with a held `bm_req`, a command code and an address, and the bus answers with a one-cycle `bm_ack`. Other masters' transactions arrive on the snoop inputs. A separate copy of the tag store serves these lookups, so a snoop stalls the processor only when both touch the same line index. A snooped read that hits a Dirty line raises `sn_retry` in the same cycle to hold memory off. The cached word is driven on the next cycle.

The bus ordering keeps a snoop and this block's own `bm_ack` out of the same cycle.

Top module: `wo_snoop_cache`

## Requirements
- R1: After `rst_n` is released, within two clock cycles, all lines are Invalid and `cpu_ready`, `bm_req`, `sn_retry` and `sn_sup_valid` are low. The first access to any address therefore misses.
- R2: A processor read miss issues exactly one bus read of that address and returns the bus data. The line becomes Valid. A later read of the same address completes in its request cycle with no bus traffic.
- R3: A processor write to a Valid line issues exactly one bus write carrying the address and the new data, and the line becomes Reserved. A write miss issues a bus read and then that bus write, and also ends Reserved.
- R4: A processor write to a Reserved line completes in its request cycle with no bus traffic, and the line becomes Dirty. Writes to a Dirty line also stay local.
- R5: A snooped write or write-back from another master whose address matches a present line makes that line Invalid. A snoop whose tag differs changes nothing.
- R6: A snooped read that hits a Reserved line moves it to Valid without asserting `sn_retry`.
- R7: A snooped read that hits a Dirty line asserts `sn_retry` in the same cycle. On the next cycle it asserts `sn_sup_valid` with the cached data. The line becomes Valid.
- R8: A snoop that hits a different line index from the pending processor request does not delay that request.
- R9: A miss whose victim is Dirty issues a bus write-back of the victim address and data before the bus read. A Valid or Reserved victim is dropped with no bus traffic.
- R10: When a snoop hit and a processor request fall on the same index in one cycle, the snoop is applied first. The processor request is not completed in that cycle and is then served against the line state the snoop left.
- R11: Bus command codes are 0 idle, 1 read, 2 write-through, 3 write-back. `bm_cmd` is 0 while `bm_req` is low. Once raised, `bm_req`, `bm_cmd` and `bm_addr` hold until `bm_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Request complete this cycle |
| cpu_rdata | output | DW | Read data, valid with `cpu_ready` |
| bm_req | output | 1 | Bus transaction request, held until `bm_ack` |
| bm_cmd | output | 2 | Bus command (R11 encoding) |
| bm_addr | output | AW | Bus address |
| bm_wdata | output | DW | Data for write-through or write-back |
| bm_ack | input | 1 | Bus completes the current transaction |
| bm_rdata | input | DW | Read data, valid with `bm_ack` |
| sn_valid | input | 1 | Another master's transaction is on the bus |
| sn_cmd | input | 2 | Its command (R11 encoding) |
| sn_addr | input | AW | Its address |
| sn_retry | output | 1 | Hold off memory: this cache owns the Dirty copy |
| sn_sup_valid | output | 1 | Supplied data is on `sn_sup_data` |
| sn_sup_data | output | DW | Dirty data supplied to the bus |

## Verification
The hardest case to reach is a snoop and a processor access landing on the same index in the same cycle while the line is Dirty. The line must first be brought to Dirty through a write miss and a second write. Then a single directed task raises the processor write and the snooped read on the same falling edge. It samples `sn_retry` and `cpu_ready` in that cycle and the supplied word in the next. The bus log then shows that the delayed write found the line clean and went out as a write-through. Line states cannot be seen at the ports, so each state is inferred from what the next processor access or snoop puts on the bus.

// File: rtl/wo_cache_pkg.sv
`timescale 1ns/1ps
package wo_cache_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_VAL = 2'd1,
    LS_RSV = 2'd2,
    LS_DRT = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE  = 2'd0,
    BC_READ  = 2'd1,
    BC_WRITE = 2'd2,
    BC_WBACK = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/wo_line_store.sv
`timescale 1ns/1ps
module wo_line_store
  import wo_cache_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  // processor-side read port
  input  logic [IDX_W-1:0] rq_idx,
  output logic [TAG_W-1:0] rq_tag,
  output line_st_e         rq_st,
  output logic [DW-1:0]    rq_data,
  // snoop-side read port (own tag copy)
  input  logic [IDX_W-1:0] sp_idx,
  output logic [TAG_W-1:0] sp_tag,
  output line_st_e         sp_st,
  output logic [DW-1:0]    sp_data,
  // request-side write port
  input  logic [IDX_W-1:0] wa_idx,
  input  logic             wa_tag_en,
  input  logic [TAG_W-1:0] wa_tag,
  input  logic             wa_st_en,
  input  line_st_e         wa_st,
  input  logic             wa_data_en,
  input  logic [DW-1:0]    wa_data,
  // snoop-side state write port (wins on a tie)
  input  logic             wb_st_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  line_st_e         wb_st
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] cpu_tag_q [LINES];
  logic [TAG_W-1:0] snp_tag_q [LINES];
  logic [DW-1:0]    data_q    [LINES];
  line_st_e         st_q      [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
    end else begin
      if (wa_st_en) st_q[wa_idx] <= wa_st;
      if (wb_st_en) st_q[wb_idx] <= wb_st;
    end
  end

  always_ff @(posedge clk) begin
    if (wa_tag_en) begin
      cpu_tag_q[wa_idx] <= wa_tag;
      snp_tag_q[wa_idx] <= wa_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (wa_data_en) data_q[wa_idx] <= wa_data;
  end

  assign rq_tag  = cpu_tag_q[rq_idx];
  assign rq_st   = st_q[rq_idx];
  assign rq_data = data_q[rq_idx];
  assign sp_tag  = snp_tag_q[sp_idx];
  assign sp_st   = st_q[sp_idx];
  assign sp_data = data_q[sp_idx];
endmodule

// File: rtl/wo_req_ctrl.sv
`timescale 1ns/1ps
module wo_req_ctrl
  import wo_cache_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int IDX_W = 3,
  localparam int TAG_W = AW - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic             cpu_ready,
  output logic [DW-1:0]    cpu_rdata,
  input  logic [TAG_W-1:0] ln_tag,
  input  line_st_e         ln_st,
  input  logic [DW-1:0]    ln_data,
  input  logic             collide,
  output logic             bm_req,
  output logic [1:0]       bm_cmd,
  output logic [AW-1:0]    bm_addr,
  output logic [DW-1:0]    bm_wdata,
  input  logic             bm_ack,
  input  logic [DW-1:0]    bm_rdata,
  output logic [IDX_W-1:0] wa_idx,
  output logic             wa_tag_en,
  output logic [TAG_W-1:0] wa_tag,
  output logic             wa_st_en,
  output line_st_e         wa_st,
  output logic             wa_data_en,
  output logic [DW-1:0]    wa_data
);
  typedef enum logic [1:0] {RQ_IDLE, RQ_WBACK, RQ_FILL, RQ_WTHRU} rq_e;

  rq_e rq_q, rq_nxt;
  logic [IDX_W-1:0] c_idx;
  logic [TAG_W-1:0] c_tag;
  logic             hit;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[AW-1:IDX_W];
  assign hit   = (ln_st != LS_INV) && (ln_tag == c_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rq_q <= RQ_IDLE;
    else        rq_q <= rq_nxt;
  end

  always_comb begin
    rq_nxt     = rq_q;
    cpu_ready  = 1'b0;
    cpu_rdata  = ln_data;
    bm_req     = 1'b0;
    bm_cmd     = BC_NONE;
    bm_addr    = cpu_addr;
    bm_wdata   = cpu_wdata;
    wa_idx     = c_idx;
    wa_tag_en  = 1'b0;
    wa_tag     = c_tag;
    wa_st_en   = 1'b0;
    wa_st      = LS_INV;
    wa_data_en = 1'b0;
    wa_data    = cpu_wdata;
    unique case (rq_q)
      RQ_IDLE: begin
        if (cpu_req && !collide) begin
          if (hit) begin
            if (!cpu_we) begin
              cpu_ready = 1'b1;
            end else if (ln_st == LS_VAL) begin
              rq_nxt = RQ_WTHRU;
            end else begin
              cpu_ready  = 1'b1;
              wa_data_en = 1'b1;
              wa_st_en   = 1'b1;
              wa_st      = LS_DRT;
            end
          end else if (ln_st == LS_DRT) begin
            rq_nxt = RQ_WBACK;
          end else begin
            rq_nxt = RQ_FILL;
          end
        end
      end
      RQ_WBACK: begin
        bm_req   = 1'b1;
        bm_cmd   = BC_WBACK;
        bm_addr  = {ln_tag, c_idx};
        bm_wdata = ln_data;
        if (bm_ack) rq_nxt = RQ_FILL;
      end
      RQ_FILL: begin
        bm_req = 1'b1;
        bm_cmd = BC_READ;
        if (bm_ack) begin
          wa_tag_en  = 1'b1;
          wa_st_en   = 1'b1;
          wa_st      = LS_VAL;
          wa_data_en = 1'b1;
          wa_data    = bm_rdata;
          rq_nxt     = RQ_IDLE;
        end
      end
      RQ_WTHRU: begin
        bm_req = 1'b1;
        bm_cmd = BC_WRITE;
        if (bm_ack) begin
          cpu_ready  = 1'b1;
          wa_st_en   = 1'b1;
          wa_st      = LS_RSV;
          wa_data_en = 1'b1;
          rq_nxt     = RQ_IDLE;
        end
      end
      default: rq_nxt = RQ_IDLE;
    endcase
  end
endmodule

// File: rtl/wo_snoop_ctrl.sv
`timescale 1ns/1ps
module wo_snoop_ctrl
  import wo_cache_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int IDX_W = 3,
  localparam int TAG_W = AW - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sn_valid,
  input  logic [1:0]       sn_cmd,
  input  logic [AW-1:0]    sn_addr,
  input  logic             cpu_req,
  input  logic [IDX_W-1:0] cpu_idx,
  output logic [IDX_W-1:0] sp_idx,
  input  logic [TAG_W-1:0] sp_tag,
  input  line_st_e         sp_st,
  input  logic [DW-1:0]    sp_data,
  output logic             collide,
  output logic             wb_st_en,
  output line_st_e         wb_st,
  output logic             sn_retry,
  output logic             sn_sup_valid,
  output logic [DW-1:0]    sn_sup_data
);
  logic          s_hit;
  logic          sup_v_q, sup_v_nxt;
  logic [DW-1:0] sup_d_q;

  assign sp_idx  = sn_addr[IDX_W-1:0];
  assign s_hit   = sn_valid && (sp_st != LS_INV) && (sp_tag == sn_addr[AW-1:IDX_W]);
  assign collide = s_hit && cpu_req && (sp_idx == cpu_idx);

  always_comb begin
    wb_st_en = 1'b0;
    wb_st    = LS_VAL;
    sn_retry = 1'b0;
    if (s_hit) begin
      unique case (sn_cmd)
        BC_READ: begin
          if (sp_st == LS_RSV || sp_st == LS_DRT) begin
            wb_st_en = 1'b1;
            wb_st    = LS_VAL;
          end
          sn_retry = (sp_st == LS_DRT);
        end
        BC_WRITE, BC_WBACK: begin
          wb_st_en = 1'b1;
          wb_st    = LS_INV;
        end
        default: wb_st_en = 1'b0;
      endcase
    end
  end

  assign sup_v_nxt = sn_retry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sup_v_q <= 1'b0;
    else        sup_v_q <= sup_v_nxt;
  end

  always_ff @(posedge clk) begin
    if (sn_retry) sup_d_q <= sp_data;
  end

  assign sn_sup_valid = sup_v_q;
  assign sn_sup_data  = sup_d_q;
endmodule

// File: rtl/wo_snoop_cache.sv
`timescale 1ns/1ps
module wo_snoop_cache
  import wo_cache_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int IDX_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          bm_req,
  output logic [1:0]    bm_cmd,
  output logic [AW-1:0] bm_addr,
  output logic [DW-1:0] bm_wdata,
  input  logic          bm_ack,
  input  logic [DW-1:0] bm_rdata,
  input  logic          sn_valid,
  input  logic [1:0]    sn_cmd,
  input  logic [AW-1:0] sn_addr,
  output logic          sn_retry,
  output logic          sn_sup_valid,
  output logic [DW-1:0] sn_sup_data
);
  localparam int TAG_W = AW - IDX_W;

  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s2, rst_s1} <= 2'b00;
    else        {rst_s2, rst_s1} <= {rst_s1, 1'b1};
  end

  logic [TAG_W-1:0] rq_tag, sp_tag, wa_tag;
  line_st_e         rq_st, sp_st, wa_st, wb_st;
  logic [DW-1:0]    rq_data, sp_data, wa_data;
  logic [IDX_W-1:0] sp_idx, wa_idx;
  logic             wa_tag_en, wa_st_en, wa_data_en, wb_st_en, collide;

  wo_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_s2),
    .rq_idx(cpu_addr[IDX_W-1:0]), .rq_tag(rq_tag), .rq_st(rq_st), .rq_data(rq_data),
    .sp_idx(sp_idx), .sp_tag(sp_tag), .sp_st(sp_st), .sp_data(sp_data),
    .wa_idx(wa_idx), .wa_tag_en(wa_tag_en), .wa_tag(wa_tag), .wa_st_en(wa_st_en),
    .wa_st(wa_st), .wa_data_en(wa_data_en), .wa_data(wa_data),
    .wb_st_en(wb_st_en), .wb_idx(sp_idx), .wb_st(wb_st)
  );

  wo_req_ctrl #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) u_req (
    .clk(clk), .rst_n(rst_s2),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .ln_tag(rq_tag), .ln_st(rq_st), .ln_data(rq_data), .collide(collide),
    .bm_req(bm_req), .bm_cmd(bm_cmd), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
    .bm_ack(bm_ack), .bm_rdata(bm_rdata),
    .wa_idx(wa_idx), .wa_tag_en(wa_tag_en), .wa_tag(wa_tag), .wa_st_en(wa_st_en),
    .wa_st(wa_st), .wa_data_en(wa_data_en), .wa_data(wa_data)
  );

  wo_snoop_ctrl #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) u_snoop (
    .clk(clk), .rst_n(rst_s2),
    .sn_valid(sn_valid), .sn_cmd(sn_cmd), .sn_addr(sn_addr),
    .cpu_req(cpu_req), .cpu_idx(cpu_addr[IDX_W-1:0]),
    .sp_idx(sp_idx), .sp_tag(sp_tag), .sp_st(sp_st), .sp_data(sp_data),
    .collide(collide), .wb_st_en(wb_st_en), .wb_st(wb_st),
    .sn_retry(sn_retry), .sn_sup_valid(sn_sup_valid), .sn_sup_data(sn_sup_data)
  );
endmodule

// File: rtl/wo_snoop_cache_chk.sv
`timescale 1ns/1ps
module wo_snoop_cache_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic          cpu_ready,
  input logic          bm_req,
  input logic [1:0]    bm_cmd,
  input logic [AW-1:0] bm_addr,
  input logic          bm_ack,
  input logic          sn_valid,
  input logic [1:0]    sn_cmd,
  input logic          sn_retry,
  input logic          sn_sup_valid
);
  assert_retry_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sn_retry |-> (sn_valid && sn_cmd == 2'd1));

  assert_supply_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sn_retry |=> sn_sup_valid);

  assert_supply_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sn_sup_valid |-> $past(sn_retry));

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && !bm_ack) |=> (bm_req && $stable(bm_cmd) && $stable(bm_addr)));

  assert_cmd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bm_req |-> (bm_cmd == 2'd0));

  assert_ready_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  assert_wthru_from_cpu_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && bm_cmd == 2'd2) |-> (cpu_req && cpu_we));
endmodule

bind wo_snoop_cache wo_snoop_cache_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
  .bm_req(bm_req), .bm_cmd(bm_cmd), .bm_addr(bm_addr), .bm_ack(bm_ack),
  .sn_valid(sn_valid), .sn_cmd(sn_cmd), .sn_retry(sn_retry), .sn_sup_valid(sn_sup_valid)
);

// File: tb/wo_snoop_cache_tb.sv
`timescale 1ns/1ps
module wo_snoop_cache_tb;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bm_req;
  logic [1:0]    bm_cmd;
  logic [AW-1:0] bm_addr;
  logic [DW-1:0] bm_wdata;
  logic          bm_ack;
  logic [DW-1:0] bm_rdata;
  logic          sn_valid;
  logic [1:0]    sn_cmd;
  logic [AW-1:0] sn_addr;
  logic          sn_retry, sn_sup_valid;
  logic [DW-1:0] sn_sup_data;

  wo_snoop_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bm_req(bm_req), .bm_cmd(bm_cmd), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
    .bm_ack(bm_ack), .bm_rdata(bm_rdata),
    .sn_valid(sn_valid), .sn_cmd(sn_cmd), .sn_addr(sn_addr),
    .sn_retry(sn_retry), .sn_sup_valid(sn_sup_valid), .sn_sup_data(sn_sup_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] mem [256];
  logic [1:0]    lg_cmd  [16];
  logic [AW-1:0] lg_addr [16];
  logic [DW-1:0] lg_data [16];
  int            lg_n = 0;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_log(input string req, input int k, input logic [1:0] c,
                           input logic [AW-1:0] a, input logic [DW-1:0] d, input logic chk_d);
    check({req, " cmd"}, 32'(lg_cmd[k]), 32'(c));
    check({req, " addr"}, 32'(lg_addr[k]), 32'(a));
    if (chk_d) check({req, " data"}, lg_data[k], d);
  endtask

  // bus memory model: acknowledges after one wait cycle
  initial begin : responder
    int waitc;
    waitc = 0;
    bm_ack = 1'b0;
    bm_rdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 | i;
    forever begin
      @(negedge clk);
      if (bm_ack) begin
        bm_ack = 1'b0;
      end else if (bm_req) begin
        if (waitc >= 1) begin
          waitc = 0;
          bm_ack = 1'b1;
          if (lg_n < 16) begin
            lg_cmd[lg_n]  = bm_cmd;
            lg_addr[lg_n] = bm_addr;
            lg_data[lg_n] = bm_wdata;
            lg_n++;
          end
          if (bm_cmd == 2'd1) bm_rdata = mem[bm_addr[7:0]];
          else                mem[bm_addr[7:0]] = bm_wdata;
        end else begin
          waitc++;
        end
      end
    end
  end

  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int stall);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    stall = 0;
    forever begin
      #2;
      if (cpu_ready) break;
      stall++;
      @(negedge clk);
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                       output logic rt, output logic sv, output logic [DW-1:0] sd);
    @(negedge clk);
    sn_valid = 1'b1; sn_cmd = c; sn_addr = a;
    #2 rt = sn_retry;
    @(negedge clk);
    sn_valid = 1'b0; sn_cmd = 2'd0;
    #2;
    sv = sn_sup_valid;
    sd = sn_sup_data;
  endtask

  task automatic t_reset();
    @(negedge clk);
    #2;
    check("R1 cpu_ready after reset", 32'(cpu_ready), 32'd0);
    check("R1 bm_req after reset", 32'(bm_req), 32'd0);
    check("R11 bm_cmd idle", 32'(bm_cmd), 32'd0);
    check("R1 sn_retry after reset", 32'(sn_retry), 32'd0);
    check("R1 sn_sup_valid after reset", 32'(sn_sup_valid), 32'd0);
  endtask

  task automatic t_read_miss();
    logic [DW-1:0] rd; int st;
    lg_n = 0;
    cpu_op(1'b0, 12'h010, '0, rd, st);
    check("R2 miss data", rd, 32'hA000_0010);
    check("R1 R2 miss bus count", 32'(lg_n), 32'd1);
    check_log("R2 fill", 0, 2'd1, 12'h010, '0, 1'b0);
    lg_n = 0;
    cpu_op(1'b0, 12'h010, '0, rd, st);
    check("R2 hit data", rd, 32'hA000_0010);
    check("R2 hit no bus", 32'(lg_n), 32'd0);
    check("R2 hit stall", 32'(st), 32'd0);
  endtask

  task automatic t_write_once();
    logic [DW-1:0] rd; int st;
    lg_n = 0;
    cpu_op(1'b1, 12'h010, 32'h1111, rd, st);
    check("R3 first write bus count", 32'(lg_n), 32'd1);
    check_log("R3 write-through", 0, 2'd2, 12'h010, 32'h1111, 1'b1);
    lg_n = 0;
    cpu_op(1'b1, 12'h010, 32'h2222, rd, st);
    check("R4 reserved write no bus", 32'(lg_n), 32'd0);
    check("R4 reserved write stall", 32'(st), 32'd0);
    cpu_op(1'b1, 12'h010, 32'h3333, rd, st);
    check("R4 dirty write no bus", 32'(lg_n), 32'd0);
    cpu_op(1'b0, 12'h010, '0, rd, st);
    check("R4 dirty read data", rd, 32'h3333);
  endtask

  task automatic t_snoop_dirty();
    logic rt, sv; logic [DW-1:0] sd, rd; int st;
    snoop(2'd1, 12'h010, rt, sv, sd);
    check("R7 retry", 32'(rt), 32'd1);
    check("R7 supply valid", 32'(sv), 32'd1);
    check("R7 supply data", sd, 32'h3333);
    lg_n = 0;
    cpu_op(1'b1, 12'h010, 32'h4444, rd, st);
    check("R7 line now valid", 32'(lg_n), 32'd1);
    check_log("R7 write-through", 0, 2'd2, 12'h010, 32'h4444, 1'b1);
  endtask

  task automatic t_snoop_reserved();
    logic rt, sv; logic [DW-1:0] sd, rd; int st;
    snoop(2'd1, 12'h010, rt, sv, sd);
    check("R6 no retry", 32'(rt), 32'd0);
    check("R6 no supply", 32'(sv), 32'd0);
    lg_n = 0;
    cpu_op(1'b1, 12'h010, 32'h5555, rd, st);
    check("R6 line now valid", 32'(lg_n), 32'd1);
    check_log("R6 write-through", 0, 2'd2, 12'h010, 32'h5555, 1'b1);
  endtask

  task automatic t_snoop_write();
    logic rt, sv; logic [DW-1:0] sd, rd; int st;
    snoop(2'd2, 12'h018, rt, sv, sd);
    lg_n = 0;
    cpu_op(1'b1, 12'h010, 32'h6666, rd, st);
    check("R5 tag miss no effect", 32'(lg_n), 32'd0);
    snoop(2'd2, 12'h010, rt, sv, sd);
    check("R5 no retry on write", 32'(rt), 32'd0);
    lg_n = 0;
    cpu_op(1'b0, 12'h010, '0, rd, st);
    check("R5 invalid refetch", 32'(lg_n), 32'd1);
    check_log("R5 refetch", 0, 2'd1, 12'h010, '0, 1'b0);
    check("R5 refetch data", rd, 32'h5555);
  endtask

  task automatic t_write_miss();
    logic [DW-1:0] rd; int st;
    lg_n = 0;
    cpu_op(1'b1, 12'h021, 32'h7777, rd, st);
    check("R3 write miss bus count", 32'(lg_n), 32'd2);
    check_log("R3 write miss read", 0, 2'd1, 12'h021, '0, 1'b0);
    check_log("R3 write miss write", 1, 2'd2, 12'h021, 32'h7777, 1'b1);
    lg_n = 0;
    cpu_op(1'b1, 12'h021, 32'h8888, rd, st);
    check("R4 after write miss no bus", 32'(lg_n), 32'd0);
  endtask

  task automatic t_evict();
    logic [DW-1:0] rd; int st;
    lg_n = 0;
    cpu_op(1'b0, 12'h029, '0, rd, st);
    check("R9 dirty victim bus count", 32'(lg_n), 32'd2);
    check_log("R9 write-back", 0, 2'd3, 12'h021, 32'h8888, 1'b1);
    check_log("R9 fill after wb", 1, 2'd1, 12'h029, '0, 1'b0);
    check("R9 new data", rd, 32'hA000_0029);
    lg_n = 0;
    cpu_op(1'b0, 12'h031, '0, rd, st);
    check("R9 valid victim silent", 32'(lg_n), 32'd1);
    check_log("R9 fill only", 0, 2'd1, 12'h031, '0, 1'b0);
    lg_n = 0;
    cpu_op(1'b1, 12'h039, 32'hCCCC, rd, st);
    check("R9 R3 miss over valid", 32'(lg_n), 32'd2);
    lg_n = 0;
    cpu_op(1'b0, 12'h021, '0, rd, st);
    check("R9 reserved victim silent", 32'(lg_n), 32'd1);
    check("R9 written-back data", rd, 32'h8888);
  endtask

  task automatic t_collide();
    logic [DW-1:0] rd; int st;
    cpu_op(1'b1, 12'h02A, 32'h1234, rd, st);
    cpu_op(1'b1, 12'h02A, 32'h9999, rd, st);
    lg_n = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 12'h02A; cpu_wdata = 32'hAAAA;
    sn_valid = 1'b1; sn_cmd = 2'd1; sn_addr = 12'h02A;
    #2;
    check("R10 retry on collision", 32'(sn_retry), 32'd1);
    check("R10 cpu held", 32'(cpu_ready), 32'd0);
    @(negedge clk);
    sn_valid = 1'b0; sn_cmd = 2'd0;
    #2;
    check("R10 supply valid", 32'(sn_sup_valid), 32'd1);
    check("R10 supply old data", sn_sup_data, 32'h9999);
    forever begin
      #2;
      if (cpu_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    check("R10 write after snoop bus count", 32'(lg_n), 32'd1);
    check_log("R10 write-through after snoop", 0, 2'd2, 12'h02A, 32'hAAAA, 1'b1);
  endtask

  task automatic t_no_stall();
    logic [DW-1:0] rd; int st;
    cpu_op(1'b1, 12'h02A, 32'hBBBB, rd, st);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 12'h02A;
    sn_valid = 1'b1; sn_cmd = 2'd2; sn_addr = 12'h010;
    #2;
    check("R8 no stall other index", 32'(cpu_ready), 32'd1);
    check("R8 hit data", cpu_rdata, 32'hBBBB);
    @(negedge clk);
    cpu_req = 1'b0; sn_valid = 1'b0; sn_cmd = 2'd0;
    lg_n = 0;
    cpu_op(1'b0, 12'h010, '0, rd, st);
    check("R8 R5 concurrent snoop applied", 32'(lg_n), 32'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    sn_valid = 1'b0; sn_cmd = 2'd0; sn_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_read_miss();
    t_write_once();
    t_snoop_dirty();
    t_snoop_reserved();
    t_snoop_write();
    t_write_miss();
    t_evict();
    t_collide();
    t_no_stall();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule